// File: doc/BRIEF.md
# Selectable Tick Divider with Conditional Pre-Scaler

This block turns one of four enable-strobe streams into a slower single-cycle tick. All sources and the output are one-cycle strobes in the system clock domain, so the whole design is synchronous. A 32-bit control word chooses the source, a post-divide ratio of 1 to 4, and a pre-scale ratio of 1 to 32. The pre-scale ratio applies only to the highest-numbered source.

Software writes the control word through a plain synchronous port and can read it back at any time. A write restarts both counting stages. The first tick after the write therefore comes after exactly one full divided period.

Top module: `tick_mux_div`

## Requirements
- R1: A synchronous active-high reset clears the control word to zero and holds `tick_out` low. Zero means source 0 with both ratios 1.
- R2: `rd_data` shows the most recently written control word, all 32 bits. It changes only in the cycle after a write.
- R3: Bits 17:16 of the control word (value 0 to 3) pick which `src_tick` bit is counted. Strobes on the other three bits are ignored.
- R4: For sources 0, 1 and 2 the pre-scale field has no effect. Every selected strobe goes straight to the post-divider.
- R5: For source 3, the pre-scaler passes one strobe out of every N. N is bits 12:8 plus one, so 1 to 32, and the boundary value 31 gives N = 32.
- R6: The post-divider emits one tick for every M strobes that reach it. M is bits 5:4 plus one, so 1 to 4.
- R7: On source 3 the overall ratio is N times M selected strobes per tick.
- R8: A write clears both counters. `tick_out` is low in the cycle after a write. A strobe arriving in the write cycle is not counted.
- R9: When the post ratio is 1 on sources 0 to 2, each selected strobe gives exactly one tick, one cycle later.
- R10: Control bits outside 17:16, 12:8 and 5:4 change nothing but the read-back value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 4 | Four enable-strobe sources |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word |
| tick_out | output | 1 | Divided single-cycle tick |

## Verification
The bound assertions check four things on every cycle:
- the write and read-back path, and that the word stays steady between writes;
- that a tick always follows a strobe on the selected source in the previous cycle;
- that a tick never follows a write;
- the one-to-one pass-through when the post ratio is 1 on sources 0 to 2.

Other behaviour needs many cycles of history, so only the bench's scenarios can show it. This covers the exact counting ratios, the product of the two stages on source 3, the 32-way boundary, and that the pre-scale field and the undefined bits are ignored. A behavioural model predicts the tick on every cycle of those scenarios.

// File: rtl/tick_mux_div.sv
module tick_mux_div #(
  parameter int DW      = 32,
  parameter int SEL_LO  = 16,
  parameter int SEL_W   = 2,
  parameter int PRE_LO  = 8,
  parameter int PRE_W   = 5,
  parameter int POST_LO = 4,
  parameter int POST_W  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2**SEL_W-1:0]  src_tick,
  input  logic                 wr_en,
  input  logic [DW-1:0]        wr_data,
  output logic [DW-1:0]        rd_data,
  output logic                 tick_out
);
  localparam int NSRC = 2**SEL_W;
  localparam logic [SEL_W-1:0] PRE_SRC = SEL_W'(NSRC - 1);

  logic [DW-1:0]     ctrl;
  logic [PRE_W-1:0]  pre_cnt;
  logic [POST_W-1:0] post_cnt;

  wire [SEL_W-1:0]  sel       = ctrl[SEL_LO +: SEL_W];
  wire [PRE_W-1:0]  pre_lim   = ctrl[PRE_LO +: PRE_W];
  wire [POST_W-1:0] post_lim  = ctrl[POST_LO +: POST_W];
  wire              strobe    = src_tick[sel];
  wire              use_pre   = (sel == PRE_SRC);
  wire              pre_wrap  = (pre_cnt == pre_lim);
  wire              pre_pulse = strobe && (!use_pre || pre_wrap);
  wire              post_wrap = (post_cnt == post_lim);

  assign rd_data = ctrl;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      pre_cnt  <= '0;
      post_cnt <= '0;
      tick_out <= 1'b0;
    end else if (wr_en) begin
      ctrl     <= wr_data;
      pre_cnt  <= '0;
      post_cnt <= '0;
      tick_out <= 1'b0;
    end else begin
      if (strobe && use_pre)
        pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
      if (pre_pulse)
        post_cnt <= post_wrap ? '0 : post_cnt + 1'b1;
      tick_out <= pre_pulse && post_wrap;
    end
  end
endmodule

// File: rtl/tick_mux_div_chk.sv
module tick_mux_div_chk (
  input logic        clk,
  input logic        rst,
  input logic [3:0]  src_tick,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        tick_out
);
  // R2
  wr_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data == $past(wr_data));

  // R2
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rd_data));

  // R8
  wr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !tick_out);

  // R3
  tick_cause_chk: assert property (@(posedge clk) disable iff (rst)
    tick_out |-> $past(src_tick[rd_data[17:16]]) && !$past(wr_en));

  // R9
  pass_thru_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && rd_data[5:4] == 2'd0 && rd_data[17:16] != 2'd3 &&
     src_tick[rd_data[17:16]]) |=> tick_out);
endmodule

bind tick_mux_div tick_mux_div_chk i_chk (
  .clk(clk), .rst(rst), .src_tick(src_tick), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .tick_out(tick_out));

// File: tb/test_tick_mux_div.sv
module test_tick_mux_div;
  logic        clk = 0;
  logic        rst = 1;
  logic [3:0]  src_tick = '0;
  logic        wr_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        tick_out;

  int checks = 0, fails = 0, ticks = 0;
  bit done = 0;
  string cur_req = "R1";

  int mctrl = 0, mpre = 0, mpost = 0;
  bit mtick = 0;

  always #4 clk = ~clk;

  tick_mux_div i_tick_mux_div (.clk(clk), .rst(rst), .src_tick(src_tick),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .tick_out(tick_out));

  always @(posedge clk) begin
    int s, n, m;
    bit go;
    if (rst) begin
      mctrl = 0; mpre = 0; mpost = 0; mtick = 0;
    end else if (wr_en) begin
      mctrl = wr_data; mpre = 0; mpost = 0; mtick = 0;
    end else begin
      s = (mctrl >> 16) & 3;
      n = ((mctrl >> 8) & 31) + 1;
      m = ((mctrl >> 4) & 3) + 1;
      go = src_tick[s];
      mtick = 0;
      if (go && s == 3) begin
        mpre++;
        if (mpre < n) go = 0; else mpre = 0;
      end
      if (go) begin
        mpost++;
        if (mpost == m) begin mpost = 0; mtick = 1; end
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk(cur_req, tick_out, mtick);
    if (tick_out) ticks++;
  endtask

  task automatic wr(logic [31:0] v);
    wr_en = 1; wr_data = v; src_tick = $urandom;
    step();
    wr_en = 0; src_tick = '0;
    chk("R2", rd_data, v);
  endtask

  task automatic run(int cyc, logic [3:0] mask);
    for (int i = 0; i < cyc; i++) begin
      src_tick = 4'($urandom) & mask;
      step();
    end
    src_tick = '0;
  endtask

  task automatic run_src(int nstrb, int s);
    for (int i = 0; i < nstrb; i++) begin
      src_tick = 4'b1 << s;
      step();
    end
    src_tick = '0;
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", rd_data, 0);
    chk("R1", tick_out, 0);
    rst = 0;
    step();
    chk("R1", tick_out, 0);

    cur_req = "R9";
    run(40, 4'hF);
    ticks = 0; run_src(10, 0);
    chk("R9", ticks, 10);

    cur_req = "R4";
    wr(32'h0001_1F20);
    run(60, 4'hF);
    ticks = 0; run_src(9, 1);
    chk("R6", ticks, 3);
    ticks = 0; run_src(9, 0);
    chk("R3", ticks, 0);

    cur_req = "R5";
    wr(32'h0003_0410);
    run(80, 4'hF);
    wr(32'h0003_0410);
    ticks = 0; run_src(40, 3);
    chk("R7", ticks, 4);

    wr(32'h0003_1F00);
    ticks = 0; run_src(31, 3);
    chk("R5", ticks, 0);
    run_src(33, 3);
    chk("R5", ticks, 2);

    cur_req = "R10";
    wr(32'hFFFE_E0CF);
    chk("R10", rd_data, 32'hFFFE_E0CF);
    run(60, 4'hF);
    ticks = 0; run_src(7, 2);
    chk("R10", ticks, 7);

    cur_req = "R8";
    wr(32'h0000_0030);
    run_src(2, 0);
    wr(32'h0000_0030);
    ticks = 0; run_src(3, 0);
    chk("R8", ticks, 0);
    run_src(1, 0);
    chk("R8", ticks, 1);
    run(60, 4'hF);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule